// File: doc/BRIEF.md
# Iterative Unit Occupancy Tracker

This block sits beside the issue stage of a dual-issue core. It watches each operation that the stage offers and decides whether the operation may issue this cycle. It keeps one countdown for the integer multiply/divide iterator and a second for the floating-point multiply and divide/square-root iterator. An operation is described by a 4-bit class code and a precision/width flag. When the operation needs an iterator that is still counting, it is refused. When it is accepted, the matching counter is loaded with the operation's occupancy. The two counters run independently of each other.

For every accepted operation, the block also reports the number of cycles until its result is ready, so that dependent operations can be held back. It does not model the arithmetic datapaths or the register file.

Top module: `occ_tracker`

## Requirements
- R1: A synchronous active-low reset (`rst_n` low at a clock edge) clears both counters, so that `int_busy`, `fp_busy` and `lat_valid` are all low in the following cycle. This holds even when an operation was in progress.
- R2: Class code 8 (integer divide) needs the integer iterator. It occupies the iterator for 36 cycles and reports latency 36 when `op_wide`=0 (32-bit). It occupies it for 68 cycles and reports latency 68 when `op_wide`=1 (64-bit).
- R3: Class code 9 (multiply writing HI/LO) with `op_wide`=0 occupies the integer iterator for 3 cycles, with latency 5. Class code 10 (multiply writing a general register) with `op_wide`=0 has latency 2 and occupies no iterator cycles, but it is still refused while the integer iterator is busy. Either code with `op_wide`=1 is a 64-bit multiply: 8 cycles of occupancy, latency 9.
- R4: Class code 12 (FP divide or square root) occupies the FP iterator for 21 cycles (`op_wide`=0) or 36 cycles (`op_wide`=1). Class code 13 (FP reciprocal square root) occupies it for 38 or 68 cycles. In each case the latency equals the occupancy.
- R5: Class code 11 (FP multiply or multiply-add) occupies the FP iterator for 1 cycle with latency 4 (`op_wide`=0), or for 2 cycles with latency 5 (`op_wide`=1).
- R6: The fixed-latency classes use no iterator and are never refused. Their latencies are: code 0 simple integer op 1, code 1 load 2, code 2 store 1, code 3 move to HI/LO 3, code 4 move from HI/LO 1, code 5 register-file transfer 2, code 6 branch 3, code 7 FP add/compare/convert/abs/neg/move 4. Codes 14 and 15 behave as code 0.
- R7: An accepted operation with occupancy N holds its iterator's busy output high for exactly the N cycles after the accepting edge. While that output is high, `op_accept` is low for any operation that needs that iterator, and the refused operation loads nothing. An operation is accepted in the first cycle in which busy is low.
- R8: A busy integer iterator never causes an FP-iterator operation to be refused, and a busy FP iterator never causes an integer-iterator operation to be refused.
- R9: `op_accept` is combinational in the same cycle as `op_valid`. In the cycle after an accepting edge, `lat_valid` is 1 and `lat_cycles` holds that operation's latency. After a cycle with no accepted operation, `lat_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| op_valid | input | 1 | An operation is offered for issue |
| op_class | input | 4 | Operation class code |
| op_wide | input | 1 | Double precision / 64-bit width flag |
| op_accept | output | 1 | Offered operation issues this cycle |
| int_busy | output | 1 | Integer iterator occupied |
| fp_busy | output | 1 | FP iterator occupied |
| lat_valid | output | 1 | Latency report valid for last accepted op |
| lat_cycles | output | 7 | Result latency of last accepted op |

## Verification
`op_accept` depends combinationally on the inputs and on the present counter state. The bench therefore samples it 1 ns after driving inputs at the falling edge, before the rising edge that would act on it. The busy outputs and the latency report each pass through one register. They are compared at the next falling edge against a cycle-accurate bench model, which decrements per rising edge and reloads on acceptance. As a result, an occupancy of N appears as exactly N sampled busy cycles, and each latency value appears exactly one sample after its acceptance.

// File: rtl/occ_pkg.sv
// Package: shared widths, class codes and iterator indices for the occupancy tracker.
// Assumes: the largest occupancy or latency fits in OCC_W bits.
package occ_pkg;
    localparam int CLS_W    = 4;
    localparam int OCC_W    = 7;
    localparam int NUM_ITER = 2;
    localparam int IT_INT   = 0;
    localparam int IT_FP    = 1;

    localparam logic [CLS_W-1:0] CLS_ALU      = 4'd0;
    localparam logic [CLS_W-1:0] CLS_LOAD     = 4'd1;
    localparam logic [CLS_W-1:0] CLS_STORE    = 4'd2;
    localparam logic [CLS_W-1:0] CLS_TO_HILO  = 4'd3;
    localparam logic [CLS_W-1:0] CLS_FROM_HL  = 4'd4;
    localparam logic [CLS_W-1:0] CLS_XFER     = 4'd5;
    localparam logic [CLS_W-1:0] CLS_BRANCH   = 4'd6;
    localparam logic [CLS_W-1:0] CLS_FPADD    = 4'd7;
    localparam logic [CLS_W-1:0] CLS_IDIV     = 4'd8;
    localparam logic [CLS_W-1:0] CLS_IMUL_HL  = 4'd9;
    localparam logic [CLS_W-1:0] CLS_IMUL_GPR = 4'd10;
    localparam logic [CLS_W-1:0] CLS_FMUL     = 4'd11;
    localparam logic [CLS_W-1:0] CLS_FDIV     = 4'd12;
    localparam logic [CLS_W-1:0] CLS_FRSQ     = 4'd13;

    typedef struct packed {
        logic [NUM_ITER-1:0] need;
        logic [OCC_W-1:0]    occ;
        logic [OCC_W-1:0]    lat;
    } op_info_t;
endpackage

// File: rtl/occ_decode.sv
// Module: occ_decode
// Maps a class code and width flag to the iterator it needs, its occupancy and its result latency.
// Assumes: unlisted class codes act as a one-cycle simple integer operation.
module occ_decode
    import occ_pkg::*;
(
    input  logic [CLS_W-1:0] cls,
    input  logic             wide,
    output op_info_t         info
);
    // Purpose: table of occupancy and latency per class and width.
    always_comb begin
        info = '{need: '0, occ: '0, lat: OCC_W'(1)};
        unique case (cls)
            CLS_LOAD, CLS_XFER:      info.lat = OCC_W'(2);
            CLS_TO_HILO, CLS_BRANCH: info.lat = OCC_W'(3);
            CLS_FPADD:               info.lat = OCC_W'(4);
            CLS_IDIV: begin
                info.need[IT_INT] = 1'b1;
                info.occ = wide ? OCC_W'(68) : OCC_W'(36);
                info.lat = info.occ;
            end
            CLS_IMUL_HL, CLS_IMUL_GPR: begin
                info.need[IT_INT] = 1'b1;
                if (wide) begin
                    info.occ = OCC_W'(8);
                    info.lat = OCC_W'(9);
                end else if (cls == CLS_IMUL_HL) begin
                    info.occ = OCC_W'(3);
                    info.lat = OCC_W'(5);
                end else begin
                    info.occ = '0;
                    info.lat = OCC_W'(2);
                end
            end
            CLS_FMUL: begin
                info.need[IT_FP] = 1'b1;
                info.occ = wide ? OCC_W'(2) : OCC_W'(1);
                info.lat = wide ? OCC_W'(5) : OCC_W'(4);
            end
            CLS_FDIV: begin
                info.need[IT_FP] = 1'b1;
                info.occ = wide ? OCC_W'(36) : OCC_W'(21);
                info.lat = info.occ;
            end
            CLS_FRSQ: begin
                info.need[IT_FP] = 1'b1;
                info.occ = wide ? OCC_W'(68) : OCC_W'(38);
                info.lat = info.occ;
            end
            default: info.lat = OCC_W'(1);
        endcase
    end
endmodule

// File: rtl/iter_counter.sv
// Module: iter_counter
// Occupancy countdown for one iterative unit; busy while the count is non-zero.
// Assumes: load is only raised while the counter is idle (the top refuses otherwise).
module iter_counter #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         busy
);
    logic [W-1:0] cnt;

    // Purpose: reset, load on acceptance, else count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= load_val;
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign busy = (cnt != '0);

    // R7: a load never lands on a running count
    assert_load_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> cnt == '0);
    // R7: load value is taken in the next cycle
    assert_load_take_R7: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> cnt == $past(load_val));
    // R7: one step down per cycle while occupied
    assert_countdown_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !load) |=> cnt == $past(cnt) - 1'b1);
endmodule

// File: rtl/lat_report.sv
// Module: lat_report
// Registers the result latency of the operation accepted in the previous cycle.
// Assumes: take is high only in a cycle where an operation is accepted.
module lat_report #(
    parameter int W = 7
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         take,
    input  logic [W-1:0] lat_in,
    output logic         lat_valid,
    output logic [W-1:0] lat_cycles
);
    // Purpose: capture latency and valid flag one cycle after acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_valid  <= 1'b0;
            lat_cycles <= '0;
        end else begin
            lat_valid <= take;
            if (take) lat_cycles <= lat_in;
        end
    end

    // R9: valid follows acceptance by one cycle
    assert_lat_follow_R9: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> lat_valid && lat_cycles == $past(lat_in));
    assert_lat_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !lat_valid);
endmodule

// File: rtl/occ_tracker.sv
// Module: occ_tracker (top)
// Structural-hazard tracker for the integer and FP iterators of a dual-issue core.
// Accepts or refuses each offered operation and reports its result latency.
// Assumes: op_class and op_wide are stable while op_valid is sampled.
module occ_tracker
    import occ_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [CLS_W-1:0] op_class,
    input  logic             op_wide,
    output logic             op_accept,
    output logic             int_busy,
    output logic             fp_busy,
    output logic             lat_valid,
    output logic [OCC_W-1:0] lat_cycles
);
    op_info_t            dec;
    logic [NUM_ITER-1:0] busy_vec;
    logic [NUM_ITER-1:0] load_vec;

    occ_decode u_dec (
        .cls  (op_class),
        .wide (op_wide),
        .info (dec)
    );

    // Purpose: refuse an op when any iterator it needs is still counting.
    assign op_accept = op_valid && ((dec.need & busy_vec) == '0);

    generate
        for (genvar i = 0; i < NUM_ITER; i++) begin : g_iter
            assign load_vec[i] = op_accept && dec.need[i];
            iter_counter #(.W(OCC_W)) u_cnt (
                .clk      (clk),
                .rst_n    (rst_n),
                .load     (load_vec[i]),
                .load_val (dec.occ),
                .busy     (busy_vec[i])
            );
        end
    endgenerate

    assign int_busy = busy_vec[IT_INT];
    assign fp_busy  = busy_vec[IT_FP];

    lat_report #(.W(OCC_W)) u_lat (
        .clk        (clk),
        .rst_n      (rst_n),
        .take       (op_accept),
        .lat_in     (dec.lat),
        .lat_valid  (lat_valid),
        .lat_cycles (lat_cycles)
    );

    // R1: reset leaves everything idle
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !int_busy && !fp_busy && !lat_valid);
    // R8: a busy integer iterator never blocks an idle FP iterator
    assert_fp_indep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !fp_busy && (op_class == CLS_FMUL || op_class == CLS_FDIV ||
         op_class == CLS_FRSQ)) |-> op_accept);
    // R8: a busy FP iterator never blocks an idle integer iterator
    assert_int_indep_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && !int_busy && (op_class == CLS_IDIV || op_class == CLS_IMUL_HL ||
         op_class == CLS_IMUL_GPR)) |-> op_accept);
    // R2: a wide integer divide occupies and reports 68
    assert_idiv_wide_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_accept && op_class == CLS_IDIV && op_wide) |=>
            int_busy && lat_cycles == OCC_W'(68));
    // R6: fixed-latency classes are never refused
    assert_fixed_accept_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && op_class <= CLS_FPADD) |-> op_accept);
endmodule

// File: tb/occ_tracker_test.sv
module occ_tracker_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [3:0] op_class = 4'd0;
    logic       op_wide = 1'b0;
    logic       op_accept, int_busy, fp_busy, lat_valid;
    logic [6:0] lat_cycles;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    // model state
    int  m_int = 0;
    int  m_fp = 0;
    bit  m_lv = 1'b0;
    int  m_lat = 0;
    string m_ltag = "R6";
    string m_itag = "R2";
    string m_ftag = "R4";

    always #2 clk = ~clk;

    occ_tracker uut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_class(op_class),
        .op_wide(op_wide), .op_accept(op_accept), .int_busy(int_busy),
        .fp_busy(fp_busy), .lat_valid(lat_valid), .lat_cycles(lat_cycles)
    );

    // iterator needed: bit0 integer, bit1 FP
    function automatic logic [1:0] f_need(input logic [3:0] c);
        if (c == 4'd8 || c == 4'd9 || c == 4'd10) return 2'b01;
        if (c == 4'd11 || c == 4'd12 || c == 4'd13) return 2'b10;
        return 2'b00;
    endfunction

    function automatic int f_occ(input logic [3:0] c, input logic w);
        case (c)
            4'd8:  return w ? 68 : 36;
            4'd9:  return w ? 8 : 3;
            4'd10: return w ? 8 : 0;
            4'd11: return w ? 2 : 1;
            4'd12: return w ? 36 : 21;
            4'd13: return w ? 68 : 38;
            default: return 0;
        endcase
    endfunction

    function automatic int f_lat(input logic [3:0] c, input logic w);
        case (c)
            4'd1, 4'd5: return 2;
            4'd3, 4'd6: return 3;
            4'd7:  return 4;
            4'd8:  return w ? 68 : 36;
            4'd9:  return w ? 9 : 5;
            4'd10: return w ? 9 : 2;
            4'd11: return w ? 5 : 4;
            4'd12: return w ? 36 : 21;
            4'd13: return w ? 68 : 38;
            default: return 1;
        endcase
    endfunction

    function automatic string f_tag(input logic [3:0] c);
        case (c)
            4'd8: return "R2";
            4'd9, 4'd10: return "R3";
            4'd11: return "R5";
            4'd12, 4'd13: return "R4";
            default: return "R6";
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // one cycle: drive at falling edge, check, advance model by one rising edge
    task automatic step(input logic v, input logic [3:0] c, input logic w);
        logic [1:0] nd;
        bit blk_own, blk_other, e_acc;
        @(negedge clk);
        op_valid = v; op_class = c; op_wide = w;
        #1;
        nd = f_need(c);
        blk_own = (nd[0] && m_int != 0) || (nd[1] && m_fp != 0);
        blk_other = (nd[0] && m_fp != 0) || (nd[1] && m_int != 0);
        e_acc = v && !blk_own;
        chk(op_accept == e_acc, (v && blk_other && !blk_own) ? "R8 accept" : "R7 accept",
            int'(op_accept), int'(e_acc));
        chk(int_busy == (m_int != 0), {"R7 int_busy ", m_itag}, int'(int_busy), int'(m_int != 0));
        chk(fp_busy == (m_fp != 0), {"R7 fp_busy ", m_ftag}, int'(fp_busy), int'(m_fp != 0));
        chk(lat_valid == m_lv, "R9 lat_valid", int'(lat_valid), int'(m_lv));
        if (m_lv) chk(int'(lat_cycles) == m_lat, {"R9 lat_cycles ", m_ltag}, int'(lat_cycles), m_lat);
        if (m_int != 0) m_int--;
        if (m_fp != 0) m_fp--;
        if (e_acc && nd[0]) begin m_int = f_occ(c, w); m_itag = f_tag(c); end
        if (e_acc && nd[1]) begin m_fp = f_occ(c, w); m_ftag = f_tag(c); end
        m_lv = e_acc;
        m_lat = f_lat(c, w);
        m_ltag = f_tag(c);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; op_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        m_int = 0; m_fp = 0; m_lv = 1'b0;
        #1;
        chk(!int_busy && !fp_busy && !lat_valid, "R1 reset idle",
            int'({int_busy, fp_busy, lat_valid}), 0);
    endtask

    initial begin
        void'($urandom(32'd20240611));
        do_reset();
        // R2: wide divide then retry until accepted
        step(1, 4'd8, 1);
        for (int k = 0; k < 72; k++) step(1, 4'd9, 0);
        // R8: FP ops while integer divide runs
        step(1, 4'd8, 0);
        step(1, 4'd12, 0);
        for (int k = 0; k < 40; k++) step(1, (k % 2) ? 4'd11 : 4'd10, k[2]);
        // R5 and R3 corner: short occupancies back to back
        for (int k = 0; k < 10; k++) step(1, 4'd11, k[0]);
        for (int k = 0; k < 6; k++) step(1, 4'd10, 0);
        // R6: every fixed class, both widths
        for (int k = 0; k < 16; k++) step(1, 4'(k), 0);
        for (int k = 0; k < 8; k++) step(1, 4'(k), 1);
        // R4: reciprocal root, both widths
        step(1, 4'd13, 1);
        for (int k = 0; k < 70; k++) step(1, 4'd13, 0);
        // R1: reset in the middle of a divide
        step(1, 4'd8, 1);
        step(0, 4'd0, 0);
        do_reset();
        step(0, 4'd0, 0);
        // random mix
        for (int k = 0; k < 4000; k++) begin
            logic vv;
            logic [3:0] cc;
            logic ww;
            vv = ($urandom % 10) < 7;
            cc = 4'($urandom % 16);
            ww = 1'($urandom % 2);
            step(vv, cc, ww);
        end
        step(0, 4'd0, 0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #(4 * 150000);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule